// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Unit

This block lets a group of CPUs interrupt one another. There is one shared register port. Every request on it carries the identifier of the CPU that issues it. All CPUs use the same register offsets, and each access reaches only the requester's own copy of the state. Each CPU has two interrupt kinds. An "other" interrupt is raised by any CPU on a chosen target. A "self" interrupt is raised by a CPU on itself. Each kind has its own pending bit and its own mask bit. A CPU's `irq` output is high while it holds at least one pending interrupt that is not masked.

A CPU handles an interrupt as follows. It reads its reason register. The read reports the interrupt to service and masks that kind straight away, so `irq` drops. The CPU then acknowledges the interrupt and clears the mask. If it clears the mask without acknowledging first, the interrupt is still pending and `irq` rises again.

Requests use a valid/ready handshake. A write needs no response. A read is answered one cycle after it is accepted, on `rsp_valid`/`rsp_rdata`, and the response is held until `rsp_ready` is high. While a response is held and `rsp_ready` is low, `req_ready` is low. A request that is not accepted has no effect.

Top module: `ipi_unit`

## Requirements
- R1: Reset clears every pending bit and sets both mask bits of every CPU. After reset all `irq` bits are low and `rsp_valid` is low.
- R2: A write to the send offset 0x2008 whose bit n is set, for n < N_CPU, sets the "other" pending bit of CPU n. The requester's identifier does not matter for this.
- R3: A write to 0x2008 with bit 31 set sets the "self" pending bit of the requesting CPU.
- R4: A write to the acknowledge offset 0x200C clears the requester's own pending bits. Bit 0 clears "other" and bit 31 clears "self". A read of 0x200C returns the requester's pending bits in those same positions.
- R5: A write to 0x2024 sets the requester's mask bits and a write to 0x2028 clears them. Bit 0 is "other" and bit 31 is "self". A read of either offset returns the current mask in those positions.
- R6: The `irq` bit of a CPU is high exactly when one of its pending bits has a clear mask bit. The change shows in the cycle after the write that caused it.
- R7: A read of the reason offset 0x2004 considers only pending bits whose mask is clear. If "self" is among them it returns 0x0003_0001: bit 17 marks an inter-processor interrupt, bit 16 marks the word valid, and bit 0 = 1 selects "self". Otherwise, if "other" is among them, it returns 0x0003_0000. If neither is, it returns 0. "Self" takes priority over "other".
- R8: An accepted reason read that reports an interrupt sets the mask bit of the reported kind, once per accepted read.
- R9: An interrupt whose mask is cleared while it is still pending raises `irq` again. An interrupt that was acknowledged before its mask is cleared does not.
- R10: A read response stays valid with a stable value until `rsp_ready` is high. While the response is stalled, `req_ready` is low, and a request offered during the stall changes no state.
- R11: A request with `req_cpu` >= N_CPU, a request to any other offset, and send bits 1..30 that name a CPU >= N_CPU all change no state. Such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register offset |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 5 | Identifier of the requesting CPU |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 32 | Read data |
| irq | output | N_CPU | Interrupt request, one per CPU |

## Verification
The bench builds the unit with N_CPU = 4. With that value, send bits 4..30 and requester identifiers 4..31 name CPUs that do not exist, so the rules for ignored targets and ignored requesters can be tested at the ports. Four CPUs are also enough to run traffic between different pairs and to check that the banks are separate: a send from CPU 3 to CPU 2, a mask change on CPU 1 and a pending interrupt on CPU 0 must not affect one another. With `rsp_ready` held low, the bench also checks the stalled-response case, where a write is offered while the response is blocked.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int CPU_ID_W = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam addr_t OFF_REASON = 16'h2004;
  localparam addr_t OFF_SEND   = 16'h2008;
  localparam addr_t OFF_ACK    = 16'h200C;
  localparam addr_t OFF_MSET   = 16'h2024;
  localparam addr_t OFF_MCLR   = 16'h2028;

  // pair index: [1] = self, [0] = other
  localparam int BIT_OTHER  = 0;
  localparam int BIT_SELF   = DATA_W - 1;
  localparam int RSN_KIND   = 0;
  localparam int RSN_VALID  = 16;
  localparam int RSN_IPI    = 17;

  typedef enum logic [2:0] {
    OP_NONE, OP_REASON, OP_SEND, OP_ACK, OP_MSET, OP_MCLR
  } op_e;

  function automatic op_e decode_op(addr_t a);
    case (a)
      OFF_REASON: return OP_REASON;
      OFF_SEND:   return OP_SEND;
      OFF_ACK:    return OP_ACK;
      OFF_MSET:   return OP_MSET;
      OFF_MCLR:   return OP_MCLR;
      default:    return OP_NONE;
    endcase
  endfunction

  function automatic word_t pair_word(logic [1:0] v);
    word_t w = '0;
    w[BIT_SELF]  = v[1];
    w[BIT_OTHER] = v[0];
    return w;
  endfunction

  function automatic logic [1:0] word_pair(word_t w);
    return {w[BIT_SELF], w[BIT_OTHER]};
  endfunction

  function automatic word_t reason_word(logic [1:0] eff);
    word_t w = '0;
    if (|eff) begin
      w[RSN_IPI]   = 1'b1;
      w[RSN_VALID] = 1'b1;
      w[RSN_KIND]  = eff[1];
    end
    return w;
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input  logic                req_valid,
  input  logic                req_ready,
  input  addr_t               req_addr,
  input  logic [CPU_ID_W-1:0] req_cpu,
  output logic                acc,
  output op_e                 op,
  output logic                cpu_ok,
  output logic [N_CPU-1:0]    sel
);
  assign acc    = req_valid && req_ready;
  assign op     = decode_op(req_addr);
  assign cpu_ok = int'(req_cpu) < N_CPU;

  for (genvar c = 0; c < N_CPU; c++) begin : g_sel
    assign sel[c] = acc && (int'(req_cpu) == c);
  end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_pend,
  input  logic [1:0] clr_pend,
  input  logic [1:0] set_mask,
  input  logic [1:0] clr_mask,
  output logic [1:0] pend,
  output logic [1:0] mask,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 2'b00;
      mask <= 2'b11;
    end else begin
      pend <= (pend & ~clr_pend) | set_pend;  // a send wins over an ack
      mask <= (mask & ~clr_mask) | set_mask;
    end
  end

  assign irq = |(pend & ~mask);
endmodule

// File: rtl/ipi_rsp.sv
module ipi_rsp
  import ipi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_data,
  input  logic  rsp_ready,
  output logic  rsp_valid,
  output word_t rsp_rdata,
  output logic  req_ready
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [CPU_ID_W-1:0]     req_cpu,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [N_CPU-1:0]        irq
);
  logic             acc, cpu_ok;
  op_e              op;
  logic [N_CPU-1:0] sel;
  logic [N_CPU-1:0] pend_o, pend_s, mask_o, mask_s;
  logic [1:0]       own_pend, own_mask, eff, claim;
  word_t            rd_word;
  logic             unused_wdata;

  assign unused_wdata = ^req_wdata;

  ipi_decode #(.N_CPU(N_CPU)) u_dec (
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .acc       (acc),
    .op        (op),
    .cpu_ok    (cpu_ok),
    .sel       (sel)
  );

  // requester's own state
  always_comb begin
    own_pend = 2'b00;
    own_mask = 2'b11;
    for (int c = 0; c < N_CPU; c++) begin
      if (int'(req_cpu) == c) begin
        own_pend = {pend_s[c], pend_o[c]};
        own_mask = {mask_s[c], mask_o[c]};
      end
    end
  end

  assign eff   = own_pend & ~own_mask;
  assign claim = eff[1] ? 2'b10 : (eff[0] ? 2'b01 : 2'b00);

  always_comb begin
    rd_word = '0;
    if (cpu_ok) begin
      case (op)
        OP_REASON:       rd_word = reason_word(eff);
        OP_ACK:          rd_word = pair_word(own_pend);
        OP_MSET, OP_MCLR: rd_word = pair_word(own_mask);
        default:         rd_word = '0;
      endcase
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic       wr_mine, rd_mine;
    logic [1:0] set_p, clr_p, set_m, clr_m, pend, mask;

    assign wr_mine = sel[c] && req_write;
    assign rd_mine = sel[c] && !req_write;

    assign set_p[0] = acc && cpu_ok && req_write && (op == OP_SEND) && req_wdata[c];
    assign set_p[1] = wr_mine && (op == OP_SEND) && req_wdata[BIT_SELF];
    assign clr_p    = (wr_mine && op == OP_ACK)  ? word_pair(req_wdata) : 2'b00;
    assign set_m    = ((wr_mine && op == OP_MSET) ? word_pair(req_wdata) : 2'b00)
                    | ((rd_mine && op == OP_REASON) ? claim : 2'b00);
    assign clr_m    = (wr_mine && op == OP_MCLR) ? word_pair(req_wdata) : 2'b00;

    ipi_cpu_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_pend (set_p),
      .clr_pend (clr_p),
      .set_mask (set_m),
      .clr_mask (clr_m),
      .pend     (pend),
      .mask     (mask),
      .irq      (irq[c])
    );

    assign pend_o[c] = pend[0];
    assign pend_s[c] = pend[1];
    assign mask_o[c] = mask[0];
    assign mask_s[c] = mask[1];
  end

  ipi_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc && !req_write),
    .load_data (rd_word),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .req_ready (req_ready)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                wdata_lsb,
  input logic [CPU_ID_W-1:0] req_cpu,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic [N_CPU-1:0]    irq,
  input logic [N_CPU-1:0]    pend_o,
  input logic [N_CPU-1:0]    pend_s,
  input logic [N_CPU-1:0]    mask_o,
  input logic [N_CPU-1:0]    mask_s
);
  logic acc, rsn_rd, in_range;
  assign acc      = req_valid && req_ready;
  assign rsn_rd   = acc && !req_write && (req_addr == OFF_REASON);
  assign in_range = int'(req_cpu) < N_CPU;

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_stall_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(pend_o) && $stable(pend_s)
                                && $stable(mask_o) && $stable(mask_s));

  assert_reason_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsn_rd |=> rsp_valid && (rsp_rdata == 32'h0 || rsp_rdata == 32'h0003_0000
                             || rsp_rdata == 32'h0003_0001));

  assert_claim_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsn_rd && in_range |=> !rsp_rdata[16]
      || (rsp_rdata[0] ? ((mask_s >> $past(req_cpu)) & 1) != 0
                       : ((mask_o >> $past(req_cpu)) & 1) != 0));

  assert_absent_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_range |=> $stable(pend_o) && $stable(pend_s)
                         && $stable(mask_o) && $stable(mask_s));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && in_range && req_addr == OFF_ACK && wdata_lsb
      |=> ((pend_o >> $past(req_cpu)) & 1) == 0);

  assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_o) && (&mask_s) |-> irq == '0);
endmodule

bind ipi_unit ipi_unit_chk #(.N_CPU(N_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .wdata_lsb (req_wdata[0]),
  .req_cpu   (req_cpu),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .pend_o    (pend_o),
  .pend_s    (pend_s),
  .mask_o    (mask_o),
  .mask_s    (mask_s)
);

// File: tb/tb_ipi_unit.sv
`timescale 1ns/1ps
module tb_ipi_unit;
  localparam int NC = 4;
  localparam int NV = 24;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic [4:0]  cpu;
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
    logic [7:0]  req;
  } vec_t;

  // wr, addr, data, cpu, expected read, expected irq, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h2024, 32'h0, 5'd0, 32'h8000_0001, 4'b0000, 8'd1},  // R1 masks set
    '{1'b0, 16'h200C, 32'h0, 5'd0, 32'h0,         4'b0000, 8'd1},  // R1 nothing pending
    '{1'b1, 16'h2008, 32'h2, 5'd0, 32'h0,         4'b0000, 8'd2},  // R2 send to cpu1
    '{1'b0, 16'h200C, 32'h0, 5'd1, 32'h1,         4'b0000, 8'd2},  // R2 cpu1 other pending
    '{1'b1, 16'h2028, 32'h1, 5'd1, 32'h0,         4'b0010, 8'd6},  // R6 unmask raises irq
    '{1'b0, 16'h2004, 32'h0, 5'd1, 32'h0003_0000, 4'b0000, 8'd8},  // R7 R8 claim other
    '{1'b0, 16'h2024, 32'h0, 5'd1, 32'h8000_0001, 4'b0000, 8'd8},  // R8 mask set by claim
    '{1'b1, 16'h2028, 32'h1, 5'd1, 32'h0,         4'b0010, 8'd9},  // R9 reassert
    '{1'b1, 16'h200C, 32'h1, 5'd1, 32'h0,         4'b0000, 8'd4},  // R4 ack other
    '{1'b1, 16'h2008, 32'h8000_0000, 5'd2, 32'h0, 4'b0000, 8'd3},  // R3 self on cpu2
    '{1'b1, 16'h2008, 32'h1, 5'd2, 32'h0,         4'b0000, 8'd2},  // R2 send to cpu0
    '{1'b1, 16'h2028, 32'h8000_0001, 5'd2, 32'h0, 4'b0100, 8'd3},  // R3 self visible
    '{1'b1, 16'h2008, 32'h4, 5'd3, 32'h0,         4'b0100, 8'd2},  // R2 cpu3 -> cpu2
    '{1'b0, 16'h2004, 32'h0, 5'd2, 32'h0003_0001, 4'b0100, 8'd7},  // R7 self first
    '{1'b0, 16'h2004, 32'h0, 5'd2, 32'h0003_0000, 4'b0000, 8'd7},  // R7 then other
    '{1'b0, 16'h2004, 32'h0, 5'd2, 32'h0,         4'b0000, 8'd7},  // R7 none left
    '{1'b1, 16'h200C, 32'h8000_0001, 5'd2, 32'h0, 4'b0000, 8'd4},  // R4 ack both
    '{1'b1, 16'h2028, 32'h8000_0001, 5'd2, 32'h0, 4'b0000, 8'd9},  // R9 acked stays low
    '{1'b1, 16'h2008, 32'h7FFF_FFF0, 5'd0, 32'h0, 4'b0000, 8'd11}, // R11 absent targets
    '{1'b1, 16'h2028, 32'h8000_0001, 5'd5, 32'h0, 4'b0000, 8'd11}, // R11 absent requester
    '{1'b1, 16'h2028, 32'h1, 5'd0, 32'h0,         4'b0001, 8'd6},  // R6 cpu0 other
    '{1'b1, 16'h2024, 32'h1, 5'd0, 32'h0,         4'b0000, 8'd5},  // R5 mask set
    '{1'b1, 16'h2030, 32'hFFFF_FFFF, 5'd0, 32'h0, 4'b0000, 8'd11}, // R11 unknown offset
    '{1'b0, 16'h200C, 32'h0, 5'd0, 32'h1,         4'b0000, 8'd11}  // R11 pending intact
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  req_cpu = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipi_unit #(.N_CPU(NC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, results sampled at following negedge
  task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [4:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'h0, "rsp_valid in reset");
    check("R1", {28'b0, irq}, 32'h0, "irq in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].cpu);
      if (!VEC[i].wr)
        check($sformatf("R%0d", VEC[i].req), rsp_rdata, VEC[i].exp_rd,
              $sformatf("row %0d read", i));
      check($sformatf("R%0d", VEC[i].req), {28'b0, irq}, {28'b0, VEC[i].exp_irq},
            $sformatf("row %0d irq", i));
    end

    // R10: stalled response, request offered during stall
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h200C; req_cpu = 5'd0;
    @(negedge clk);
    req_write = 1'b1; req_addr = 16'h2008; req_wdata = 32'h8000_0000; req_cpu = 5'd2;
    check("R10", {31'b0, rsp_valid}, 32'h1, "response valid");
    check("R10", rsp_rdata, 32'h1, "response data");
    repeat (3) @(negedge clk);
    check("R10", {31'b0, req_ready}, 32'h0, "ready low during stall");
    check("R10", rsp_rdata, 32'h1, "data held during stall");
    check("R10", {28'b0, irq}, 32'h0, "stalled send had no effect");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", {31'b0, rsp_valid}, 32'h0, "response consumed");
    check("R3", {28'b0, irq}, 32'h4, "send taken after stall");
    access(1'b1, 16'h200C, 32'h8000_0000, 5'd2);
    check("R4", {28'b0, irq}, 32'h0, "self ack on cpu2");

    // R1: reset in the middle of a run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 16'h2024, 32'h0, 5'd1);
    check("R1", rsp_rdata, 32'h8000_0001, "mask after second reset");
    access(1'b1, 16'h2028, 32'h8000_0001, 5'd0);
    check("R1", {28'b0, irq}, 32'h0, "pending cleared by reset");

    finish_run();
  end

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule